// File: doc/BRIEF.md
# Dual Fractional Store Scaling Unit

This block prepares a pair of signed fractional words for a single 32-bit memory write. Each of two 40-bit accumulator values is shifted according to a selectable scaling mode. It can then be clamped to the signed 16-bit fractional range. The high portion of each result is taken as the word to store. The two words are placed on the write bus so that the first word always lands at the lower halfword address, whichever byte order is in force.

The effective address must fall on a 4-byte boundary. When it does not, the write is dropped and an error pulse is raised. Each stored pair is also screened for a magnitude between one quarter and three quarters of full scale. A hit sets a sticky detect bit, which only an explicit clear or reset can lower. All outputs are registered and appear one clock after the valid strobe.

Top module: `dfs_store_unit`

## Requirements
- R1: Scaling mode encoding: 2'b00 and 2'b11 leave the 40-bit value unchanged, 2'b01 shifts it right arithmetically by one bit, and 2'b10 shifts it left by one bit within 40 bits, dropping the top bit.
- R2: When `sat_mode_i` is 1, no shift is applied, whatever the value of `scale_mode_i`.
- R3: When `limit_en_i` is 1, a scaled value whose bits [39:31] are not all equal is stored as 16'h7FFF if bit 39 is 0, or as 16'h8000 if bit 39 is 1. Otherwise the stored word is scaled bits [31:16].
- R4: When `limit_en_i` is 0, the stored word is scaled bits [31:16], with the upper bits discarded.
- R5: Little-endian packing (`big_endian_i`=0): word A is placed in `wr_data_o[15:0]` and word B in `wr_data_o[31:16]`.
- R6: Big-endian packing (`big_endian_i`=1): word A is placed in `wr_data_o[31:16]` and word B in `wr_data_o[15:0]`.
- R7: After a valid strobe with `addr_i[1:0]`==0, the next cycle shows `wr_en_o`=1, `wr_be_o`=4'hF, `align_err_o`=0, and `wr_addr_o` equal to the strobed address.
- R8: After a valid strobe with `addr_i[1:0]`!=0, the next cycle shows `align_err_o`=1, `wr_en_o`=0 and `wr_be_o`=0. The detect bit is not updated.
- R9: Without a valid strobe, the next cycle shows `wr_en_o`=0, `align_err_o`=0 and `wr_be_o`=0.
- R10: A stored word v counts as a detect hit when 16'h2000 <= |v| < 16'h6000. The magnitude of 16'h8000 is taken as 16'h8000, so that value is not a hit.
- R11: `sdet_o` is sticky. At each edge, the next value is the old value (or 0 when `sdet_clr_i`=1), ORed with a hit on either word of an aligned valid store. Reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Store request strobe |
| acc_a_i | input | 40 | First register value (goes to lower address) |
| acc_b_i | input | 40 | Second register value (goes to address + 2) |
| scale_mode_i | input | 2 | Scaling mode selector |
| sat_mode_i | input | 1 | Scaling bypass flag |
| limit_en_i | input | 1 | Enable 16-bit fractional limiting |
| big_endian_i | input | 1 | Byte-order mode, 1 = big endian |
| addr_i | input | 32 | Effective byte address |
| sdet_clr_i | input | 1 | Clear the sticky detect bit |
| wr_en_o | output | 1 | Write strobe |
| wr_addr_o | output | 32 | Write address |
| wr_data_o | output | 32 | Packed write data |
| wr_be_o | output | 4 | Byte enables |
| align_err_o | output | 1 | Misaligned-address pulse |
| sdet_o | output | 1 | Sticky scaling-detect status |

## Verification
The bench builds the block with its default parameters: 40-bit registers with 8 extension bits, 16-bit words and a 32-bit address. At these widths a left shift can carry a value out of the 16-bit window through both the extension bits and bit 31. The saturation corners 16'h7FFF and 16'h8000 can therefore be reached both from a raw input and from a scaled one. The 16-bit word width also places the detect thresholds at 16'h2000 and 16'h6000, and a negative full-scale word at 16'h8000. Each of these can be hit exactly with directed values, and about a thousand random stores across all mode combinations complete the coverage.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

  typedef enum logic [1:0] {
    SCL_NONE = 2'b00,
    SCL_DOWN = 2'b01,
    SCL_UP   = 2'b10,
    SCL_RSVD = 2'b11
  } scale_mode_e;

  // Arithmetic shift of a wide accumulator by the selected mode.
  function automatic logic [39:0] scale_acc(input logic [39:0] acc,
                                            input scale_mode_e mode,
                                            input logic bypass);
    logic [39:0] res;
    if (bypass) begin
      res = acc;
    end else begin
      case (mode)
        SCL_DOWN: res = {acc[39], acc[39:1]};
        SCL_UP:   res = {acc[38:0], 1'b0};
        default:  res = acc;
      endcase
    end
    return res;
  endfunction

  // True when the top 9 bits (extension plus bit 31) disagree.
  function automatic logic out_of_range(input logic [39:0] v);
    return !((&v[39:31]) || !(|v[39:31]));
  endfunction

  // Select the stored 16-bit word, clamping when asked.
  function automatic logic [15:0] pick_word(input logic [39:0] v,
                                            input logic limit);
    logic [15:0] w;
    if (limit && out_of_range(v)) begin
      w = v[39] ? 16'h8000 : 16'h7FFF;
    end else begin
      w = v[31:16];
    end
    return w;
  endfunction

  // Magnitude window test in Q15: 0.25 <= |w| < 0.75.
  function automatic logic in_window(input logic [15:0] w);
    logic [16:0] mag;
    mag = w[15] ? (17'h10000 - {1'b0, w}) : {1'b0, w};
    return (mag >= 17'h02000) && (mag < 17'h06000);
  endfunction

endpackage

// File: rtl/dfs_lane.sv
module dfs_lane
  import dfs_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 16
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [1:0]        mode_i,
  input  logic              bypass_i,
  input  logic              limit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              hit_o
);

  logic [39:0] acc_ext;
  logic [39:0] scaled;
  logic [15:0] word_int;
  logic        unused_lane;

  assign acc_ext  = 40'(acc_i);
  assign scaled   = scale_acc(acc_ext, scale_mode_e'(mode_i), bypass_i);
  assign word_int = pick_word(scaled, limit_i);
  assign word_o   = WORD_W'(word_int);
  assign hit_o    = in_window(word_int);
  assign unused_lane = ^scaled[15:0];

endmodule

// File: rtl/dfs_pack.sv
module dfs_pack #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0]   word_a_i,
  input  logic [WORD_W-1:0]   word_b_i,
  input  logic                big_i,
  output logic [2*WORD_W-1:0] bus_o
);

  always_comb begin
    if (big_i) begin
      bus_o = {word_a_i, word_b_i};
    end else begin
      bus_o = {word_b_i, word_a_i};
    end
  end

endmodule

// File: rtl/dfs_store_unit.sv
module dfs_store_unit #(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid_i,
  input  logic [ACC_W-1:0]    acc_a_i,
  input  logic [ACC_W-1:0]    acc_b_i,
  input  logic [1:0]          scale_mode_i,
  input  logic                sat_mode_i,
  input  logic                limit_en_i,
  input  logic                big_endian_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                sdet_clr_i,
  output logic                wr_en_o,
  output logic [ADDR_W-1:0]   wr_addr_o,
  output logic [2*WORD_W-1:0] wr_data_o,
  output logic [2*WORD_W/8-1:0] wr_be_o,
  output logic                align_err_o,
  output logic                sdet_o
);

  localparam int BUS_W   = 2 * WORD_W;
  localparam int BE_W    = BUS_W / 8;
  localparam int ALIGN_B = $clog2(BE_W);
  localparam int LANES   = 2;

  logic [ACC_W-1:0]  acc_w  [LANES];
  logic [WORD_W-1:0] word_w [LANES];
  logic [LANES-1:0]  hit_w;
  logic [BUS_W-1:0]  packed_w;
  logic              aligned_w;
  logic              store_ok_w;
  logic              det_set_w;
  logic              sdet_nx;

  assign acc_w[0] = acc_a_i;
  assign acc_w[1] = acc_b_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dfs_lane #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_lane (
      .acc_i    (acc_w[g]),
      .mode_i   (scale_mode_i),
      .bypass_i (sat_mode_i),
      .limit_i  (limit_en_i),
      .word_o   (word_w[g]),
      .hit_o    (hit_w[g])
    );
  end

  dfs_pack #(.WORD_W(WORD_W)) u_pack (
    .word_a_i (word_w[0]),
    .word_b_i (word_w[1]),
    .big_i    (big_endian_i),
    .bus_o    (packed_w)
  );

  assign aligned_w  = (addr_i[ALIGN_B-1:0] == '0);
  assign store_ok_w = valid_i && aligned_w;
  assign det_set_w  = store_ok_w && (|hit_w);
  assign sdet_nx    = (sdet_clr_i ? 1'b0 : sdet_o) | det_set_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o     <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_be_o     <= '0;
      align_err_o <= 1'b0;
      sdet_o      <= 1'b0;
    end else begin
      wr_en_o     <= store_ok_w;
      wr_be_o     <= store_ok_w ? {BE_W{1'b1}} : '0;
      align_err_o <= valid_i && !aligned_w;
      sdet_o      <= sdet_nx;
      if (store_ok_w) begin
        wr_addr_o <= addr_i;
        wr_data_o <= packed_w;
      end
    end
  end

endmodule

// File: rtl/dfs_store_chk.sv
module dfs_store_chk #(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              sdet_clr_i,
  input logic              wr_en_o,
  input logic [BE_W-1:0]   wr_be_o,
  input logic              align_err_o,
  input logic              sdet_o,
  input logic [1:0]        hit_w
);

  // R7
  aligned_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && addr_i[1:0] == 2'b00 |=> wr_en_o && wr_be_o == '1 && !align_err_o);

  // R8
  misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && addr_i[1:0] != 2'b00 |=> align_err_o && !wr_en_o && wr_be_o == '0);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !wr_en_o && !align_err_o && wr_be_o == '0);

  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdet_o && !sdet_clr_i |=> sdet_o);

  // R11
  detect_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && addr_i[1:0] == 2'b00 && (|hit_w) |=> sdet_o);

  // R8
  misalign_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdet_o && (!valid_i || addr_i[1:0] != 2'b00) |=> !sdet_o);

endmodule

bind dfs_store_unit dfs_store_chk #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .valid_i     (valid_i),
  .addr_i      (addr_i),
  .sdet_clr_i  (sdet_clr_i),
  .wr_en_o     (wr_en_o),
  .wr_be_o     (wr_be_o),
  .align_err_o (align_err_o),
  .sdet_o      (sdet_o),
  .hit_w       (hit_w)
);

// File: tb/dfs_store_unit_tb_top.sv
module dfs_store_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [39:0] acc_a_i, acc_b_i;
  logic [1:0]  scale_mode_i;
  logic        sat_mode_i, limit_en_i, big_endian_i, sdet_clr_i;
  logic [31:0] addr_i;
  logic        wr_en_o;
  logic [31:0] wr_addr_o;
  logic [31:0] wr_data_o;
  logic [3:0]  wr_be_o;
  logic        align_err_o;
  logic        sdet_o;

  int checks = 0;
  int fails  = 0;
  bit sdet_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dfs_store_unit dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
    .acc_a_i(acc_a_i), .acc_b_i(acc_b_i), .scale_mode_i(scale_mode_i),
    .sat_mode_i(sat_mode_i), .limit_en_i(limit_en_i), .big_endian_i(big_endian_i),
    .addr_i(addr_i), .sdet_clr_i(sdet_clr_i), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_be_o(wr_be_o),
    .align_err_o(align_err_o), .sdet_o(sdet_o)
  );

  // Reference: R1 R2 shift as signed integer arithmetic, wrapped to 40 bits.
  function automatic longint ref_scale(logic [39:0] a, logic [1:0] m, bit sat);
    longint v;
    v = longint'($signed(a));
    if (!sat) begin
      if (m == 2'd2) begin
        v = v * 2;
        v = (v <<< 24) >>> 24;
      end else if (m == 2'd1) begin
        v = v >>> 1;
      end
    end
    return v;
  endfunction

  // Reference: R3 R4 range clamp expressed by comparison.
  function automatic logic [15:0] ref_word(longint v, bit lim);
    longint hi;
    if (lim && v > 64'sh7FFF_FFFF) return 16'h7FFF;
    if (lim && v < -64'sh8000_0000) return 16'h8000;
    hi = v >>> 16;
    return hi[15:0];
  endfunction

  // Reference: R10 window test with integers.
  function automatic bit ref_hit(logic [15:0] w);
    int s;
    s = int'($signed(w));
    if (s < 0) s = -s;
    return (s >= 8192) && (s < 24576);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic store(logic [39:0] a, logic [39:0] b, logic [1:0] m, bit sat,
                       bit lim, bit big, logic [31:0] ad, bit clr);
    logic [15:0] wa, wb;
    logic [31:0] exp_d;
    bit ok;
    wa = ref_word(ref_scale(a, m, sat), lim);
    wb = ref_word(ref_scale(b, m, sat), lim);
    exp_d = big ? {wa, wb} : {wb, wa};
    ok = (ad[1:0] == 2'b00);
    valid_i = 1'b1; acc_a_i = a; acc_b_i = b; scale_mode_i = m;
    sat_mode_i = sat; limit_en_i = lim; big_endian_i = big; addr_i = ad;
    sdet_clr_i = clr;
    @(negedge clk);
    valid_i = 1'b0; sdet_clr_i = 1'b0;
    sdet_m = (clr ? 1'b0 : sdet_m) | (ok && (ref_hit(wa) || ref_hit(wb)));
    if (ok) begin
      chk(big ? "R6 data" : "R5 data", wr_data_o, exp_d);
      chk("R7 wr_en", wr_en_o, 1);
      chk("R7 be", wr_be_o, 4'hF);
      chk("R7 addr", wr_addr_o, ad);
      chk("R7 err", align_err_o, 0);
    end else begin
      chk("R8 err", align_err_o, 1);
      chk("R8 wr_en", wr_en_o, 0);
      chk("R8 be", wr_be_o, 0);
    end
    chk("R11 sdet", sdet_o, sdet_m);
  endtask

  task automatic idle(bit clr);
    valid_i = 1'b0; sdet_clr_i = clr;
    @(negedge clk);
    sdet_clr_i = 1'b0;
    if (clr) sdet_m = 1'b0;
    chk("R9 wr_en", wr_en_o, 0);
    chk("R9 err", align_err_o, 0);
    chk("R9 be", wr_be_o, 0);
    chk("R11 sdet", sdet_o, sdet_m);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; valid_i = 0; acc_a_i = 0; acc_b_i = 0; scale_mode_i = 0;
    sat_mode_i = 0; limit_en_i = 0; big_endian_i = 0; addr_i = 0; sdet_clr_i = 0;
    repeat (3) @(negedge clk);
    chk("reset wr_en", wr_en_o, 0);
    chk("reset sdet", sdet_o, 0);
    chk("reset be", wr_be_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 shift modes, no limit, little endian
    store(40'h00_1234_0000, 40'h00_0100_0000, 2'b00, 0, 0, 0, 32'h100, 1);
    store(40'h00_1234_0000, 40'hFF_8000_0000, 2'b01, 0, 0, 0, 32'h104, 1);
    store(40'h00_1234_0000, 40'h00_4000_0000, 2'b10, 0, 0, 0, 32'h108, 1);
    store(40'h00_1234_0000, 40'h00_0100_0000, 2'b11, 0, 0, 0, 32'h10C, 1);
    // R2 bypass overrides scale-up
    store(40'h00_4000_0000, 40'h00_1000_0000, 2'b10, 1, 1, 0, 32'h110, 1);
    // R3 clamp positive and negative, via input and via scale-up
    store(40'h01_0000_0000, 40'hFE_0000_0000, 2'b00, 0, 1, 0, 32'h120, 1);
    store(40'h00_4000_0000, 40'hFF_8000_0000, 2'b10, 0, 1, 0, 32'h124, 1);
    // R4 truncation without limit
    store(40'h01_2345_0000, 40'hFE_0000_0000, 2'b10, 0, 0, 0, 32'h128, 1);
    // R6 big endian
    store(40'h00_AAAA_0000, 40'h00_5555_0000, 2'b00, 0, 0, 1, 32'h130, 1);
    // R8 misaligned, detect would hit but must not set
    store(40'h00_3000_0000, 40'h00_3000_0000, 2'b00, 0, 0, 0, 32'h132, 1);
    store(40'h00_3000_0000, 40'h00_3000_0000, 2'b00, 0, 0, 1, 32'h133, 0);
    // R10 window edges
    store(40'h00_1FFF_0000, 40'h00_6000_0000, 2'b00, 0, 0, 0, 32'h140, 1);
    store(40'hFF_8000_0000, 40'h00_0000_0000, 2'b00, 0, 1, 0, 32'h144, 1);
    store(40'h00_2000_0000, 40'h00_0000_0000, 2'b00, 0, 0, 0, 32'h148, 1);
    store(40'h00_0000_0000, 40'hFF_A001_0000, 2'b00, 0, 0, 0, 32'h14C, 1);
    store(40'hFF_E000_0000, 40'h00_0000_0000, 2'b00, 0, 0, 0, 32'h150, 1);
    // R11 sticky hold across a non-hit store, then clear, then clear with a set
    store(40'h00_0000_0000, 40'h00_0000_0000, 2'b00, 0, 0, 0, 32'h154, 0);
    idle(0);
    idle(1);
    store(40'h00_3000_0000, 40'h00_0000_0000, 2'b00, 0, 0, 0, 32'h158, 0);
    store(40'h00_3000_0000, 40'h00_0000_0000, 2'b00, 0, 0, 0, 32'h15C, 1);
    // R9 idle
    idle(0);

    for (int i = 0; i < 1000; i++) begin
      logic [39:0] ra, rb;
      logic [31:0] ad;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      if ($urandom_range(1, 0) == 1) ra[39:31] = {9{ra[39]}};
      if ($urandom_range(1, 0) == 1) rb[39:31] = {9{rb[39]}};
      ad = $urandom();
      if ($urandom_range(3, 0) != 0) ad[1:0] = 2'b00;
      if ($urandom_range(9, 0) == 0) idle($urandom_range(1, 0) == 1);
      store(ra, rb, 2'($urandom()), $urandom_range(3, 0) == 0,
            $urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1, ad,
            $urandom_range(4, 0) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule